// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. It watches three control levels (an active-high enable, an active-low select and a read/convert line) and starts a conversion on the clock where their combined condition first becomes true. A conversion begins with a fixed acquisition window, during which the sample control is asserted. The block then tests one bit per clock, from the most significant bit down. For each test it drives a trial code to the DAC and keeps or drops the bit according to a single comparator input.

A busy flag covers the whole conversion. While it is high, new start conditions are ignored, and nothing can abort the conversion. The level of the address-select input A0 is captured at the start. A high level selects a short conversion that stops after the upper eight bits and pads the low bits with a fixed pattern. The final code appears on a result port in the same clock that busy drops, and it stays unchanged until the next start.

Top module: `sar_conv_seq`

## Requirements
- R1: The start condition is `ce & ~cs_n & ~rc`, sampled on each rising clock edge. A start occurs on the first edge where the condition is true after an edge where it was false, whichever of the three inputs changed last.
- R2: On the edge that accepts a start, the trial code and the result are both cleared to zero, and busy and sample rise.
- R3: Sample stays high for exactly two clocks after the start edge. On the edge where it falls, the trial code becomes only its top bit set (12'h800).
- R4: Each following clock decides one bit, working downward from bit 11. The bit under test is kept when `cmp` is 1 (the DAC code is below the held input) and cleared when `cmp` is 0. The next lower bit is set as the new trial.
- R5: With A0 low at start, busy stays high for 14 clocks (two for acquisition and twelve for decisions) and falls on the edge of the bit-0 decision.
- R6: A start condition that appears while busy is high neither restarts nor alters the conversion. A condition still held true when busy falls does not start a new conversion.
- R7: A0 is captured on the start edge. A captured 1 ends the conversion after eight decisions (busy high for 10 clocks). Changes on A0 during a conversion have no effect.
- R8: After a short conversion, result bits 11..4 hold the eight decisions, bit 3 reads 1 and bits 2..0 read 0.
- R9: The result takes its final value on the edge where busy falls and holds it while busy is low.
- R10: Synchronous active-high reset clears busy, sample, the trial code and the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Enable, active high |
| cs_n | input | 1 | Select, active low |
| rc | input | 1 | Read/convert; low requests a conversion |
| a0 | input | 1 | Length select, latched at start (1 = 8-bit) |
| cmp | input | 1 | Comparator: 1 when the DAC code is below the held input |
| dac_code | output | 12 | Trial code driven to the DAC |
| sample | output | 1 | High while the input is being acquired |
| busy | output | 1 | High while a conversion is in progress |
| result | output | 12 | Final conversion code |

## Verification
The assertions assume that `cmp` is a settled function of the current trial code and of an input value that is stable for the whole conversion, and that reset is held from time zero. The bench meets this by modelling the comparator as `dac_code <= vin` and by changing `vin` only while busy is low. It drives all control inputs on the falling edge, so each start is seen at a single well-defined rising edge. When it makes a start or a reset land in the middle of a conversion, it does so on purpose, to test lockout and reset, and not through races.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_BITS = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_start_detect.sv
module sar_start_detect (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic cs_n,
  input  logic rc,
  output logic start_o
);
  logic cond_now;
  logic cond_q;

  assign cond_now = ce & ~cs_n & ~rc;

  always_ff @(posedge clk) begin
    if (rst) cond_q <= 1'b0;
    else     cond_q <= cond_now;
  end

  // rising edge of the combined request, whichever input moved last
  assign start_o = cond_now & ~cond_q;
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic                     a0_i,
  output logic                     busy_o,
  output logic                     sample_o,
  output logic                     clr_o,
  output logic                     arm_o,
  output logic                     decide_o,
  output logic                     last_o,
  output logic                     short_o,
  output logic [$clog2(WIDTH)-1:0] idx_o
);
  localparam int IDXW = $clog2(WIDTH);
  localparam int ACQW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1;
  localparam logic [IDXW-1:0] STOP_SHORT = IDXW'(WIDTH - SHORT_BITS);
  localparam logic [IDXW-1:0] TOP_IDX    = IDXW'(WIDTH - 1);
  localparam logic [ACQW-1:0] ACQ_LAST   = ACQW'(ACQ_CYCLES - 1);

  phase_t          phase;
  logic [ACQW-1:0] acq_cnt;
  logic [IDXW-1:0] idx;
  logic            short_q;
  logic [IDXW-1:0] stop_idx;

  assign stop_idx = short_q ? STOP_SHORT : '0;
  assign clr_o    = (phase == PH_IDLE) && start_i;
  assign arm_o    = (phase == PH_ACQ) && (acq_cnt == ACQ_LAST);
  assign decide_o = (phase == PH_BITS);
  assign last_o   = decide_o && (idx == stop_idx);
  assign idx_o    = idx;
  assign short_o  = short_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      acq_cnt  <= '0;
      idx      <= TOP_IDX;
      short_q  <= 1'b0;
      busy_o   <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_i) begin
            phase    <= PH_ACQ;
            acq_cnt  <= '0;
            short_q  <= a0_i;
            busy_o   <= 1'b1;
            sample_o <= 1'b1;
          end
        end
        PH_ACQ: begin
          if (arm_o) begin
            phase    <= PH_BITS;
            sample_o <= 1'b0;
            idx      <= TOP_IDX;
          end else begin
            acq_cnt <= acq_cnt + 1'b1;
          end
        end
        PH_BITS: begin
          if (last_o) begin
            phase  <= PH_IDLE;
            busy_o <= 1'b0;
          end else begin
            idx <= idx - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assert_sample_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> busy_o);
  assert_length_latched_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(short_q));
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (decide_o && start_i) |=> !sample_o);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr_i,
  input  logic                     arm_i,
  input  logic                     decide_i,
  input  logic                     last_i,
  input  logic                     short_i,
  input  logic [$clog2(WIDTH)-1:0] idx_i,
  input  logic                     cmp_i,
  output logic [WIDTH-1:0]         code_o,
  output logic [WIDTH-1:0]         result_o
);
  localparam int PADN = WIDTH - SHORT_BITS;

  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      nxt[i] = work_q[i];
      if (clr_i) begin
        nxt[i] = 1'b0;
      end else if (arm_i) begin
        if (i == WIDTH - 1) nxt[i] = 1'b1;
      end else if (decide_i) begin
        if (int'(idx_i) == i)
          nxt[i] = cmp_i;
        else if (!last_i && (int'(idx_i) - 1 == i))
          nxt[i] = 1'b1;
        else if (last_i && short_i && (i < PADN))
          nxt[i] = (i == PADN - 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q   <= '0;
      result_o <= '0;
    end else begin
      work_q <= nxt;
      if (clr_i)                result_o <= '0;
      else if (decide_i && last_i) result_o <= nxt;
    end
  end

  assign code_o = work_q;

  assert_bit_decision_R4: assert property (@(posedge clk) disable iff (rst)
    decide_i |=> (work_q[$past(idx_i)] == $past(cmp_i)));
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (work_q == '0 && result_o == '0));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int WIDTH      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             cs_n,
  input  logic             rc,
  input  logic             a0,
  input  logic             cmp,
  output logic [WIDTH-1:0] dac_code,
  output logic             sample,
  output logic             busy,
  output logic [WIDTH-1:0] result
);
  localparam int IDXW   = $clog2(WIDTH);
  localparam int MAXLEN = ACQ_CYCLES + WIDTH;
  localparam int CNTW   = $clog2(MAXLEN + 2);

  logic            start_w;
  logic            clr_w, arm_w, decide_w, last_w, short_w;
  logic [IDXW-1:0] idx_w;

  sar_start_detect u_start (
    .clk(clk), .rst(rst), .ce(ce), .cs_n(cs_n), .rc(rc), .start_o(start_w)
  );

  sar_seq_ctrl #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS), .ACQ_CYCLES(ACQ_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_w), .a0_i(a0),
    .busy_o(busy), .sample_o(sample), .clr_o(clr_w), .arm_o(arm_w),
    .decide_o(decide_w), .last_o(last_w), .short_o(short_w), .idx_o(idx_w)
  );

  sar_trial_reg #(.WIDTH(WIDTH), .SHORT_BITS(SHORT_BITS)) u_reg (
    .clk(clk), .rst(rst), .clr_i(clr_w), .arm_i(arm_w), .decide_i(decide_w),
    .last_i(last_w), .short_i(short_w), .idx_i(idx_w), .cmp_i(cmp),
    .code_o(dac_code), .result_o(result)
  );

  // busy-window length checked with a counter rather than a deep $past
  logic [CNTW-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_busy_window_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(busy_len) < MAXLEN));
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> $stable(result));
  assert_msb_trial_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sample) |-> (dac_code == {1'b1, {(WIDTH-1){1'b0}}}));
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!busy && !sample && dac_code == '0 && result == '0));
endmodule

// File: tb/sim_sar_conv_seq.sv
module sim_sar_conv_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b1, cs_n = 1'b0, rc = 1'b1, a0 = 1'b0;
  logic [11:0] vin = 12'd0;
  logic cmp;
  logic [11:0] dac_code, result;
  logic sample, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign cmp = (dac_code <= vin);

  sar_conv_seq u0 (
    .clk(clk), .rst(rst), .ce(ce), .cs_n(cs_n), .rc(rc), .a0(a0), .cmp(cmp),
    .dac_code(dac_code), .sample(sample), .busy(busy), .result(result)
  );

  // behavioural reference: cycle count since start and a trial value
  logic        m_busy = 0, m_sample = 0, m_short = 0, m_condq = 0;
  logic [11:0] m_code = 0, m_res = 0;
  int          m_cnt = 0;

  always @(posedge clk) begin
    bit cond;
    int dec, bitpos, need;
    cond = ce && !cs_n && !rc;
    cyc++;
    if (rst) begin
      m_busy = 0; m_sample = 0; m_code = 0; m_res = 0; m_cnt = 0; m_condq = 0;
    end else begin
      if (!m_busy) begin
        if (cond && !m_condq) begin
          m_busy = 1; m_sample = 1; m_code = 0; m_res = 0; m_cnt = 0; m_short = a0;
        end
      end else begin
        m_cnt++;
        if (m_cnt == 2) begin
          m_sample = 0; m_code = 12'h800;
        end else if (m_cnt > 2) begin
          dec = m_cnt - 2;
          bitpos = 12 - dec;
          need = m_short ? 8 : 12;
          if (!(m_code <= vin)) m_code[bitpos] = 1'b0;
          if (dec == need) begin
            if (m_short) m_code[3:0] = 4'b1000;
            m_res = m_code;
            m_busy = 0;
          end else begin
            m_code[bitpos-1] = 1'b1;
          end
        end
      end
      m_condq = cond;
    end
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 busy", {11'd0, busy}, {11'd0, m_busy});
      chk("R3 sample", {11'd0, sample}, {11'd0, m_sample});
      chk("R4 dac_code", dac_code, m_code);
      chk("R9 result", result, m_res);
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  // kind: 0 = rc last, 1 = ce last, 2 = cs_n last
  task automatic convert(input int kind, input logic a0v, input logic [11:0] v,
                         input int poke_at, input int a0_flip_at, output int len);
    @(negedge clk);
    vin = v; a0 = a0v;
    ce = 1; cs_n = 0; rc = 1;
    if (kind == 1) begin ce = 0; rc = 0; end
    if (kind == 2) begin cs_n = 1; rc = 0; end
    @(negedge clk);
    if (kind == 0) rc = 0;
    if (kind == 1) ce = 1;
    if (kind == 2) cs_n = 0;
    len = 0;
    @(negedge clk);
    while (busy && len < 40) begin
      len++;
      if (len == poke_at) rc = 1;
      if (len == poke_at + 1) rc = 0;
      if (len == a0_flip_at) a0 = ~a0;
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 busy after reset", {11'd0, busy}, 12'd0);
    chk("R10 result after reset", result, 12'd0);
    chk("R10 sample after reset", {11'd0, sample}, 12'd0);
    rst = 0;
    @(negedge clk);
    chk("R10 dac after reset", dac_code, 12'd0);

    // R1/R5/R4: full conversion started by rc
    convert(0, 0, 12'hA5C, 0, 0, len);
    chk("R5 length 12-bit", 12'(len), 12'd14);
    chk("R4 code rc start", result, 12'hA5C);

    // R1: ce last, R1: cs_n last
    convert(1, 0, 12'h001, 0, 0, len);
    chk("R1 ce-last start", 12'(len), 12'd14);
    chk("R4 code 001", result, 12'h001);
    convert(2, 0, 12'hFFF, 0, 0, len);
    chk("R1 cs-last start", 12'(len), 12'd14);
    chk("R4 code FFF", result, 12'hFFF);
    convert(0, 0, 12'h000, 0, 0, len);
    chk("R4 code 000", result, 12'h000);

    // R6: lockout of restart while busy; held condition does not restart
    convert(0, 0, 12'h3C7, 5, 0, len);
    chk("R6 length with restart poke", 12'(len), 12'd14);
    chk("R6 result unaffected", result, 12'h3C7);
    repeat (3) @(negedge clk);
    chk("R6 no restart on held request", {11'd0, busy}, 12'd0);

    // R7/R8: short conversion
    convert(0, 1, 12'hB7F, 0, 0, len);
    chk("R7 short length", 12'(len), 12'd10);
    chk("R8 short pad", result, 12'hB78);
    convert(1, 1, 12'h00E, 0, 0, len);
    chk("R8 short pad low", result, 12'h008);

    // R7: A0 flips during conversion have no effect
    convert(0, 0, 12'h6D2, 0, 4, len);
    chk("R7 a0 flip long", 12'(len), 12'd14);
    chk("R7 a0 flip long code", result, 12'h6D2);
    convert(0, 1, 12'h6D2, 0, 3, len);
    chk("R7 a0 flip short", 12'(len), 12'd10);
    chk("R7 a0 flip short code", result, 12'h6D8);

    // R9: result held while idle even with vin changing
    rc = 1; vin = 12'h123;
    repeat (5) @(negedge clk);
    chk("R9 result held idle", result, 12'h6D8);

    // R2: start clears code and result
    rc = 0;
    @(negedge clk);
    chk("R2 result cleared at start", result, 12'h000);
    chk("R2 code cleared at start", dac_code, 12'h000);
    // R10: reset in mid conversion
    repeat (6) @(negedge clk);
    rst = 1;
    @(negedge clk);
    chk("R10 busy mid reset", {11'd0, busy}, 12'd0);
    chk("R10 code mid reset", dac_code, 12'd0);
    rst = 0; rc = 1;
    repeat (3) @(negedge clk);
    convert(2, 0, 12'h800, 0, 0, len);
    chk("R4 code 800", result, 12'h800);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule